// File: doc/BRIEF.md
# Same-Line Load Batch Selector

This block sits at the front of a load pipeline. It keeps an age-ordered queue of memory operations that are already cleared to issue. Every cycle it takes the oldest live entry. When that entry is a load, it also gathers younger loads that fall in the same 64-byte cache line, so one cache access can serve several loads. Each selected entry is placed on one of the ready execution ports. A per-port multiplexer then drives that entry's address, tag and kind onto the port.

The gathering scan stops at an ordering barrier: a fence, an atomic, or a store to the head load's line. Selection is done with log-depth prefix-count networks, in the manner of a carry-lookahead tree. One tree finds barriers ahead of each entry. One ranks the candidate loads by age. One ranks the ready ports. An entry whose rank matches a ready port's rank takes that port.

Issued entries are not compacted out of the queue. They are flagged dead. The head pointer jumps over any run of dead entries at the front in the same cycle.

Top module: `lbs_batch_select`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, every port_valid bit is 0 and enq_ready is 1.
- R2: Whenever the queue is non-empty and at least one port_ready bit is set, the head (oldest live) entry issues on the lowest-numbered ready port.
- R3: When the head is a load (kind 0), younger live loads whose address bits [31:6] equal the head's also issue in the same cycle. They are taken in queue order and placed on the ready ports in ascending port order. Matching loads beyond the number of ready ports stay queued for a later cycle.
- R4: A load whose address bits [31:6] differ from the head load's does not issue in that cycle, even when ports are free.
- R5: The scan ends at the first younger fence (kind 2), atomic (kind 3) or store (kind 1) to the head's line. No load behind that point issues in that cycle. A store to another line does not end the scan.
- R6: A store, fence or atomic issues only from the head of the queue, and it issues alone, on the lowest ready port with its kind on port_kind.
- R7: An issued entry is removed from the queue and never issues again. Remaining entries keep their relative order.
- R8: A port whose port_ready bit is 0 never shows port_valid. With no ready port, nothing issues and the queue is unchanged.
- R9: The queue holds 16 slots, counted from the head to the youngest entry, including dead ones in between. enq_ready is 0 when all 16 are occupied, and an enqueue attempted then is ignored.
- R10: In the same cycle as the removal, the head moves past any run of dead entries at the front of the queue. The slots it passes become free for enqueue from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_kind | input | 2 | Operation kind: 0 load, 1 store, 2 fence, 3 atomic |
| enq_addr | input | 32 | Byte address of the operation |
| enq_tag | input | 6 | Identifier returned with the issued operation |
| enq_ready | output | 1 | Queue has a free slot |
| port_ready | input | 4 | Per-port ready to accept an operation this cycle |
| port_valid | output | 4 | Per-port operation issued this cycle |
| port_addr | output | 4x32 | Per-port issued address |
| port_tag | output | 4x6 | Per-port issued tag |
| port_kind | output | 4x2 | Per-port issued kind |

## Verification
The assertions assume that every enqueued operation already carries a legal kind code. They also assume the environment honours enq_ready, so no write lands on an occupied slot. On that basis they treat the head slot as always live and issued slots as dead on the next cycle. The bench only ever drives the four defined kinds. It counts an enqueue as accepted only when enq_ready was high in that cycle, so a refused write never enters its reference queue. The random addresses fall on only four cache lines, which makes same-line batches, conflicting stores and port overflow frequent.

// File: rtl/lbs_pkg.sv
// Shared definitions for the load batch selector.
// Assumes: kind is carried as a 2-bit code on all ports.
package lbs_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_FENCE  = 2'd2,
        OP_ATOMIC = 2'd3
    } op_kind_e;
endpackage

// File: rtl/lbs_prefix_count.sv
// Log-depth exclusive prefix count (Hillis-Steele tree).
// Output i is the number of set input bits at positions below i.
// Assumes: CW >= 2 and CW is wide enough to hold N.
module lbs_prefix_count #(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic [N-1:0]         bits_i,
    output logic [N-1:0][CW-1:0] excl_o
);
    localparam int LV = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] acc [LV+1][N];

    genvar i, s;
    generate
        for (i = 0; i < N; i++) begin : g_in
            assign acc[0][i] = {{(CW-1){1'b0}}, bits_i[i]};
        end
        for (s = 0; s < LV; s++) begin : g_lvl
            for (i = 0; i < N; i++) begin : g_node
                if (i >= (1 << s)) begin : g_add
                    assign acc[s+1][i] = acc[s][i] + acc[s][i-(1<<s)];
                end else begin : g_pass
                    assign acc[s+1][i] = acc[s][i];
                end
            end
        end
        for (i = 0; i < N; i++) begin : g_out
            assign excl_o[i] = acc[LV][i] - {{(CW-1){1'b0}}, bits_i[i]};
        end
    endgenerate
endmodule

// File: rtl/lbs_port_mux.sv
// Per-port steering. Port p takes the candidate whose age rank equals
// that port's rank among the ready ports, and forwards its fields.
// Assumes: candidate ranks are distinct, so each match is at most one entry.
module lbs_port_mux #(
    parameter int DEPTH = 16,
    parameter int NPORT = 4,
    parameter int RW    = 5,
    parameter int AW    = 32,
    parameter int TW    = 6
) (
    input  logic [DEPTH-1:0]           cand_i,
    input  logic [DEPTH-1:0][RW-1:0]   rank_i,
    input  logic [NPORT-1:0]           ready_i,
    input  logic [NPORT-1:0][RW-1:0]   slot_i,
    input  logic [DEPTH-1:0][AW-1:0]   addr_i,
    input  logic [DEPTH-1:0][TW-1:0]   tag_i,
    input  logic [DEPTH-1:0][1:0]      kind_i,
    output logic [NPORT-1:0]           valid_o,
    output logic [NPORT-1:0][AW-1:0]   addr_o,
    output logic [NPORT-1:0][TW-1:0]   tag_o,
    output logic [NPORT-1:0][1:0]      kind_o,
    output logic [DEPTH-1:0]           take_o
);
    // Match ranks to ready ports and OR-collect the one matching entry.
    always_comb begin
        valid_o = '0;
        addr_o  = '0;
        tag_o   = '0;
        kind_o  = '0;
        take_o  = '0;
        for (int p = 0; p < NPORT; p++) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (ready_i[p] && cand_i[j] && rank_i[j] == slot_i[p]) begin
                    valid_o[p] = 1'b1;
                    addr_o[p]  = addr_o[p] | addr_i[j];
                    tag_o[p]   = tag_o[p]  | tag_i[j];
                    kind_o[p]  = kind_o[p] | kind_i[j];
                    take_o[j]  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lbs_batch_select.sv
// Same-line load batch selector. Circular queue of ready memory operations.
// Each cycle the head issues. If it is a load, younger same-line loads up to
// the first barrier issue with it, one per ready port, oldest first.
// Issued slots are flagged dead and the head skips leading dead slots.
// Assumes: DEPTH is a power of two; the caller honours enq_ready.
module lbs_batch_select
    import lbs_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int NPORT    = 4,
    parameter int AW       = 32,
    parameter int TW       = 6,
    parameter int LINE_OFS = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [1:0]                 enq_kind,
    input  logic [AW-1:0]              enq_addr,
    input  logic [TW-1:0]              enq_tag,
    output logic                       enq_ready,
    input  logic [NPORT-1:0]           port_ready,
    output logic [NPORT-1:0]           port_valid,
    output logic [NPORT-1:0][AW-1:0]   port_addr,
    output logic [NPORT-1:0][TW-1:0]   port_tag,
    output logic [NPORT-1:0][1:0]      port_kind
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = IW + 1;
    localparam int LW = AW - LINE_OFS;

    logic [DEPTH-1:0]          live;
    logic [DEPTH-1:0][1:0]     q_kind;
    logic [DEPTH-1:0][AW-1:0]  q_addr;
    logic [DEPTH-1:0][TW-1:0]  q_tag;
    logic [IW-1:0]             head;
    logic [CW-1:0]             occ;

    logic [DEPTH-1:0]          r_live;
    logic [DEPTH-1:0][1:0]     r_kind;
    logic [DEPTH-1:0][AW-1:0]  r_addr;
    logic [DEPTH-1:0][TW-1:0]  r_tag;
    logic [LW-1:0]             head_line;
    logic                      head_load;
    logic [DEPTH-1:0]          same_line;
    logic [DEPTH-1:0]          barrier;
    logic [DEPTH-1:0][CW-1:0]  bar_cnt;
    logic [DEPTH-1:0]          cand;
    logic [DEPTH-1:0][CW-1:0]  rank;
    logic [NPORT-1:0][CW-1:0]  port_rank;
    logic [DEPTH-1:0]          take_r;
    logic [DEPTH-1:0]          take_s;
    logic [CW-1:0]             lead;
    logic [CW-1:0]             adv;
    logic                      enq_fire;
    logic [IW-1:0]             tail;

    // Rotate the queue so that index 0 is the head.
    always_comb begin
        logic [IW-1:0] slot;
        for (int j = 0; j < DEPTH; j++) begin
            slot      = head + IW'(j);
            r_live[j] = live[slot];
            r_kind[j] = q_kind[slot];
            r_addr[j] = q_addr[slot];
            r_tag[j]  = q_tag[slot];
        end
    end

    assign head_line = r_addr[0][AW-1:LINE_OFS];
    assign head_load = (r_kind[0] == OP_LOAD);

    // Classify each entry against the head's line.
    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            same_line[j] = (r_addr[j][AW-1:LINE_OFS] == head_line);
            barrier[j]   = r_live[j] && (r_kind[j] == OP_FENCE || r_kind[j] == OP_ATOMIC ||
                                         (r_kind[j] == OP_STORE && same_line[j]));
        end
    end

    lbs_prefix_count #(.N(DEPTH), .CW(CW)) u_bar (.bits_i(barrier), .excl_o(bar_cnt));

    // Candidates: the head always; younger same-line loads ahead of any barrier.
    always_comb begin
        cand[0] = r_live[0];
        for (int j = 1; j < DEPTH; j++) begin
            cand[j] = head_load && r_live[j] && r_kind[j] == OP_LOAD &&
                      same_line[j] && bar_cnt[j] == '0;
        end
    end

    lbs_prefix_count #(.N(DEPTH), .CW(CW)) u_rank (.bits_i(cand), .excl_o(rank));
    lbs_prefix_count #(.N(NPORT), .CW(CW)) u_prdy (.bits_i(port_ready), .excl_o(port_rank));

    lbs_port_mux #(.DEPTH(DEPTH), .NPORT(NPORT), .RW(CW), .AW(AW), .TW(TW)) u_mux (
        .cand_i (cand),
        .rank_i (rank),
        .ready_i(port_ready),
        .slot_i (port_rank),
        .addr_i (r_addr),
        .tag_i  (r_tag),
        .kind_i (r_kind),
        .valid_o(port_valid),
        .addr_o (port_addr),
        .tag_o  (port_tag),
        .kind_o (port_kind),
        .take_o (take_r)
    );

    // Map issued entries back to physical slots.
    always_comb begin
        take_s = '0;
        for (int j = 0; j < DEPTH; j++) begin
            take_s[head + IW'(j)] = take_r[j];
        end
    end

    // Count dead entries at the front after this cycle's removals.
    always_comb begin
        logic run;
        run  = 1'b1;
        lead = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (run && !(r_live[j] && !take_r[j])) lead = lead + CW'(1);
            else run = 1'b0;
        end
        adv = (lead > occ) ? occ : lead;
    end

    assign enq_ready = (occ != CW'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign tail      = head + occ[IW-1:0];

    // Live flags, head pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            head <= '0;
            occ  <= '0;
        end else begin
            live <= live & ~take_s;
            if (enq_fire) live[tail] <= 1'b1;
            head <= head + adv[IW-1:0];
            occ  <= occ - adv + CW'(enq_fire);
        end
    end

    // Payload storage, written at the tail on enqueue.
    always_ff @(posedge clk) begin
        if (enq_fire) begin
            q_kind[tail] <= enq_kind;
            q_addr[tail] <= enq_addr;
            q_tag[tail]  <= enq_tag;
        end
    end

    // ---------------- assertions ----------------
    p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> (occ == '0 && live == '0));

    p_head_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0 && port_ready != '0) |-> take_r[0]);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    p_head_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0) |-> live[head]);

    p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid & ~port_ready) == '0);

    genvar gp, gs;
    generate
        for (gp = 0; gp < NPORT; gp++) begin : g_port_chk
            p_barrier_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (port_valid[gp] && port_kind[gp] != OP_LOAD) |-> $countones(port_valid) == 1);
            p_same_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (port_valid[gp] && port_kind[gp] == OP_LOAD) |->
                (port_addr[gp][AW-1:LINE_OFS] == head_line));
        end
        for (gs = 0; gs < DEPTH; gs++) begin : g_slot_chk
            p_removed_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
                take_s[gs] |=> !live[gs]);
        end
    endgenerate
endmodule

// File: tb/tb_lbs_batch_select.sv
module tb_lbs_batch_select;
    localparam int NP = 4;
    localparam int QD = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enq_valid = 1'b0;
    logic [1:0]         enq_kind = '0;
    logic [31:0]        enq_addr = '0;
    logic [5:0]         enq_tag = '0;
    logic               enq_ready;
    logic [NP-1:0]      port_ready = '0;
    logic [NP-1:0]      port_valid;
    logic [NP-1:0][31:0] port_addr;
    logic [NP-1:0][5:0] port_tag;
    logic [NP-1:0][1:0] port_kind;

    lbs_batch_select dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_addr(enq_addr),
        .enq_tag(enq_tag), .enq_ready(enq_ready),
        .port_ready(port_ready), .port_valid(port_valid),
        .port_addr(port_addr), .port_tag(port_tag), .port_kind(port_kind)
    );

    always #5 clk = ~clk;

    // reference queue: index 0 is the oldest entry
    logic [1:0]  m_kind [QD];
    logic [31:0] m_addr [QD];
    logic [5:0]  m_tag  [QD];
    bit          m_dead [QD];
    int          m_len = 0;
    int          e_idx [NP];
    int          n_chk = 0;
    int          n_bad = 0;
    int          next_tag = 0;
    bit          done = 0;

    function automatic logic [31:0] mk(int line, int off);
        return (32'(line) << 6) | 32'(off & 63);
    endfunction

    // expected selection, computed by a sequential walk of the reference queue
    function automatic void pick(logic [NP-1:0] rdy);
        int  nxt;
        bool_loop: begin end
        for (int p = 0; p < NP; p++) e_idx[p] = -1;
        nxt = 0;
        if (m_len == 0) return;
        for (int j = 0; j < m_len; j++) begin
            bit take;
            take = 0;
            if (m_dead[j]) continue;
            if (j == 0) take = 1;
            else begin
                if (m_kind[0] != 2'd0) break;
                if (m_kind[j] == 2'd2 || m_kind[j] == 2'd3) break;
                if (m_kind[j] == 2'd1) begin
                    if (m_addr[j][31:6] == m_addr[0][31:6]) break;
                    continue;
                end
                take = (m_addr[j][31:6] == m_addr[0][31:6]);
            end
            if (take) begin
                while (nxt < NP && !rdy[nxt]) nxt++;
                if (nxt >= NP) break;
                e_idx[nxt] = j;
                nxt++;
            end
        end
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(logic [NP-1:0] rdy, bit ev, logic [1:0] ek, logic [31:0] ea, string req);
        bit exp_rdy;
        @(negedge clk);
        port_ready = rdy;
        enq_valid  = ev;
        enq_kind   = ek;
        enq_addr   = ea;
        enq_tag    = 6'(next_tag);
        #1;
        pick(rdy);
        exp_rdy = (m_len < QD);
        chk(enq_ready == exp_rdy, req, "enq_ready", 32'(enq_ready), 32'(exp_rdy));
        for (int p = 0; p < NP; p++) begin
            bit ev_p;
            ev_p = (e_idx[p] >= 0);
            chk(port_valid[p] == ev_p, req, $sformatf("port%0d valid", p), 32'(port_valid[p]), 32'(ev_p));
            if (ev_p && port_valid[p]) begin
                chk(port_tag[p] == m_tag[e_idx[p]], req, $sformatf("port%0d tag", p),
                    32'(port_tag[p]), 32'(m_tag[e_idx[p]]));
                chk(port_addr[p] == m_addr[e_idx[p]], req, $sformatf("port%0d addr", p),
                    port_addr[p], m_addr[e_idx[p]]);
                chk(port_kind[p] == m_kind[e_idx[p]], req, $sformatf("port%0d kind", p),
                    32'(port_kind[p]), 32'(m_kind[e_idx[p]]));
            end
        end
        @(posedge clk);
        for (int p = 0; p < NP; p++) if (e_idx[p] >= 0) m_dead[e_idx[p]] = 1;
        while (m_len > 0 && m_dead[0]) begin
            for (int k = 0; k < QD - 1; k++) begin
                m_kind[k] = m_kind[k+1]; m_addr[k] = m_addr[k+1];
                m_tag[k]  = m_tag[k+1];  m_dead[k] = m_dead[k+1];
            end
            m_len--;
        end
        if (ev && exp_rdy) begin
            m_kind[m_len] = ek; m_addr[m_len] = ea;
            m_tag[m_len] = 6'(next_tag); m_dead[m_len] = 0;
            m_len++;
        end
        next_tag++;
    endtask

    task automatic put(logic [1:0] k, logic [31:0] a, string req);
        step('0, 1, k, a, req);
    endtask

    task automatic drain(string req);
        for (int i = 0; i < 40 && m_len > 0; i++) step('1, 0, 2'd0, '0, req);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset, ports ready but nothing to issue
        step('1, 0, 2'd0, '0, "R1");

        // R3 / R4 / R10: batch of same-line loads with one foreign line
        put(2'd0, mk(1, 0),  "R8");
        put(2'd0, mk(1, 8),  "R8");
        put(2'd0, mk(2, 0),  "R8");
        put(2'd0, mk(1, 16), "R8");
        put(2'd0, mk(1, 24), "R8");
        put(2'd0, mk(1, 32), "R8");
        step('0, 0, 2'd0, '0, "R8");
        step('1, 0, 2'd0, '0, "R3");
        step('1, 0, 2'd0, '0, "R4");
        step('1, 0, 2'd0, '0, "R10");
        drain("R7");

        // R5: store to another line is skipped, fence stops the scan
        put(2'd0, mk(3, 0), "R5");
        put(2'd1, mk(5, 0), "R5");
        put(2'd0, mk(3, 4), "R5");
        put(2'd2, mk(0, 0), "R5");
        put(2'd0, mk(3, 8), "R5");
        step('1, 0, 2'd0, '0, "R5");
        step('1, 0, 2'd0, '0, "R6");
        drain("R7");

        // R5: store to the head's line stops the scan
        put(2'd0, mk(3, 0), "R5");
        put(2'd1, mk(3, 0), "R5");
        put(2'd0, mk(3, 4), "R5");
        step('1, 0, 2'd0, '0, "R5");
        drain("R6");

        // R6 / R2: atomic at head issues alone on lowest ready port
        put(2'd3, mk(4, 0), "R6");
        put(2'd0, mk(4, 4), "R6");
        step(4'b0110, 0, 2'd0, '0, "R6");
        step(4'b1000, 0, 2'd0, '0, "R2");
        drain("R2");

        // R9: fill all slots, then an ignored enqueue
        for (int i = 0; i < QD; i++) put(2'd0, mk(7, i * 4), "R9");
        put(2'd0, mk(7, 60), "R9");
        step(4'b0011, 0, 2'd0, '0, "R9");
        put(2'd0, mk(7, 61), "R10");
        drain("R9");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] k;
            r = int'($urandom % 100);
            k = (r < 70) ? 2'd0 : (r < 85) ? 2'd1 : (r < 93) ? 2'd2 : 2'd3;
            step(NP'($urandom), ($urandom % 10) < 7, k,
                 mk(int'($urandom % 4), int'($urandom % 64)), "R3");
        end
        drain("R7");

        done = 1;
        summary();
        $finish;
    end
endmodule